// File: doc/BRIEF.md
# UART Register Front-End with Divisor-Latch Banking

This block is the bus-facing register bank of a 16550-style serial port. It sits on a 32-bit bus whose registers are spaced four bytes apart. It decodes every access into one of the port's control and status registers and holds the configuration bytes. It drives single-cycle load strobes toward the transmitter and the FIFO controller. It also owns the receive side up to the bus: a single holding register for non-FIFO operation, a parameterised receive FIFO for FIFO operation, and the data-ready flag.

Bit 7 of the line control byte is the latch-access bit. When it is set, the two lowest word slots stop addressing the data and interrupt-enable registers and address the two bytes of the baud divisor instead. The slot at byte offset 0x08 ignores this bit. Reads of that slot return interrupt identification, supplied from outside. Writes to that slot load FIFO control. The serial shifters, the baud generator and the interrupt prioritiser live elsewhere and connect through plain ports.

Data-ready is kept by a two-state machine. In state RX_EMPTY, an arriving character moves it to RX_READY; a flush keeps it in RX_EMPTY. In RX_READY, a flush returns it to RX_EMPTY. A data read with no character arriving in the same cycle also returns it to RX_EMPTY, when that read takes the last stored character. Every other case holds the current state.

Top module: `uart_regbank`

## Requirements
- R1: With line control bit 7 clear, a write to offset 0x00 produces a one-cycle `tx_wr` pulse with `tx_byte` equal to write data bits [7:0]. A read of offset 0x00 returns the receive byte. Offset 0x04 is the read/write interrupt-enable byte, shown on `ier`.
- R2: With line control bit 7 set, offsets 0x00 and 0x04 read and write the divisor low and high bytes, shown as `divisor` = {high, low}. No `tx_wr` pulse occurs, and `ier` keeps its value.
- R3: Offset 0x08 reads return `iir_in` whatever the value of line control bit 7. Writes to 0x08 produce a one-cycle `fcr_wr` pulse and load `fcr_byte`. Bit 0 of the written value is `fifo_mode`, and bit 1 requests a receive flush.
- R4: Line control (0x0C), modem control (0x10), scratch (0x1C) and infrared select (0x20) are read/write bytes. Reads return them in bits [7:0] with bits [31:8] zero.
- R5: Line status (0x14) reads as {`lsr_in`, data-ready} with data-ready in bit 0. Modem status (0x18) reads as `msr_in`. Writes to either offset change nothing.
- R6: In non-FIFO mode an arriving character is stored and sets data-ready; a newer character overwrites an unread one. A data read returns the stored character, clears data-ready and empties the register, so that a second read returns 0.
- R7: Line control bits [1:0] select a character length of 5, 6, 7 or 8 bits (codes 0 to 3). A receive read returns only that many low bits and returns 0 in the bits above.
- R8: In FIFO mode, data reads pop the FIFO in arrival order. Data-ready stays 1 until the last byte is read. A read of an empty FIFO returns 0. Characters that arrive while the FIFO is full are dropped. An FCR write with bit 1 set empties the FIFO.
- R9: Offsets 0x24 to 0x3C read 0, and writes to them change no register.
- R10: After reset every output is 0 and data-ready is 0.
- R11: Read data appears on `bus_rdata` one cycle after the request, and address bits [1:0] are ignored.
- R12: An FCR write that changes `fifo_mode` discards all stored receive data and clears data-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset from base |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rx_valid | input | 1 | Receive shifter has a character |
| rx_char | input | 8 | Received character |
| iir_in | input | 8 | Interrupt identification byte |
| msr_in | input | 8 | Modem status byte |
| lsr_in | input | 7 | Line status bits [7:1] |
| data_ready | output | 1 | Receive data available |
| tx_wr | output | 1 | Transmit holding load strobe |
| tx_byte | output | 8 | Transmit byte |
| fcr_wr | output | 1 | FIFO control load strobe |
| fcr_byte | output | 8 | Last FIFO control byte |
| fifo_mode | output | 1 | FIFO mode enabled |
| lcr | output | 8 | Line control byte |
| ier | output | 8 | Interrupt enable byte |
| mcr | output | 8 | Modem control byte |
| irsel | output | 8 | Infrared select byte |
| divisor | output | 16 | Baud divisor |

## Verification
Each access is presented during one cycle and latched at one rising edge. After that edge, `bus_rdata`, the `tx_wr` and `fcr_wr` strobes, the configuration outputs and `data_ready` all hold their new values, one cycle after the stimulus. The strobes fall again after the following edge. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge that updates the results. The bench's own model of the receive path is updated at that same point.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    // Which register an access lands on after address and bank decode.
    typedef enum logic [3:0] {
        RID_DATA,
        RID_IER,
        RID_DIVLO,
        RID_DIVHI,
        RID_IDFC,
        RID_LCTL,
        RID_MCTL,
        RID_LSTAT,
        RID_MSTAT,
        RID_SCR,
        RID_IRS,
        RID_NONE
    } reg_id_t;

    typedef enum logic {
        RX_EMPTY,
        RX_READY
    } rx_state_t;

    // Word slot numbers (byte offset / 4).
    localparam int unsigned SLOT_DATA  = 0;
    localparam int unsigned SLOT_IER   = 1;
    localparam int unsigned SLOT_IDFC  = 2;
    localparam int unsigned SLOT_LCTL  = 3;
    localparam int unsigned SLOT_MCTL  = 4;
    localparam int unsigned SLOT_LSTAT = 5;
    localparam int unsigned SLOT_MSTAT = 6;
    localparam int unsigned SLOT_SCR   = 7;
    localparam int unsigned SLOT_IRS   = 8;

    localparam int unsigned BANK_BIT = 7;

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
#(
    parameter int unsigned SLOT_W = 4
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic              bank_sel,
    output reg_id_t           rid
);

    always_comb begin
        unique case (int'(slot))
            SLOT_DATA:  rid = bank_sel ? RID_DIVLO : RID_DATA;
            SLOT_IER:   rid = bank_sel ? RID_DIVHI : RID_IER;
            SLOT_IDFC:  rid = RID_IDFC;
            SLOT_LCTL:  rid = RID_LCTL;
            SLOT_MCTL:  rid = RID_MCTL;
            SLOT_LSTAT: rid = RID_LSTAT;
            SLOT_MSTAT: rid = RID_MSTAT;
            SLOT_SCR:   rid = RID_SCR;
            SLOT_IRS:   rid = RID_IRS;
            default:    rid = RID_NONE;
        endcase
    end

endmodule

// File: rtl/uart_rb_rxfifo.sv
module uart_rb_rxfifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             last_one
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, push_ok, pop_ok;

    assign empty    = (count == '0);
    assign full     = (count == FULL_CNT);
    assign last_one = (count == CNT_W'(1));
    assign pop_ok   = pop && !empty;
    assign push_ok  = push && (!full || pop_ok);
    assign head     = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (push_ok && !flush && (wr_ptr == PTR_W'(g)))
                    mem[g] <= din;
            end
        end
    endgenerate

endmodule

// File: rtl/uart_rb_rxpath.sv
module uart_rb_rxpath
    import uart_rb_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_on,
    input  logic       flush,
    input  logic       rx_valid,
    input  logic [7:0] rx_char,
    input  logic       take,
    input  logic [1:0] char_len,
    output logic [7:0] rd_byte,
    output logic       ready
);

    rx_state_t  state_q, state_d;
    logic [7:0] hold_q;
    logic [7:0] head, raw, keep_mask;
    logic       f_empty, f_last;
    logic       f_push, f_pop, arrive, drained;

    assign f_push = rx_valid && fifo_on;
    assign f_pop  = take && fifo_on;

    uart_rb_rxfifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (f_push),
        .din      (rx_char),
        .pop      (f_pop),
        .head     (head),
        .empty    (f_empty),
        .last_one (f_last)
    );

    // Single-character holder used outside FIFO mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   hold_q <= '0;
        else if (flush)               hold_q <= '0;
        else if (!fifo_on && rx_valid) hold_q <= rx_char;
        else if (!fifo_on && take)     hold_q <= '0;
    end

    assign arrive  = rx_valid;
    assign drained = take && !rx_valid && (fifo_on ? f_last : 1'b1);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (!flush && arrive) state_d = RX_READY;
            RX_READY: if (flush || drained) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    // Outputs.
    always_comb begin
        keep_mask = 8'hFF >> (2'd3 - char_len);
        raw       = fifo_on ? (f_empty ? 8'h00 : head) : hold_q;
        rd_byte   = raw & keep_mask;
        ready     = (state_q == RX_READY);
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 6,
    parameter int unsigned FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_char,
    input  logic [7:0]        iir_in,
    input  logic [7:0]        msr_in,
    input  logic [6:0]        lsr_in,
    output logic              data_ready,
    output logic              tx_wr,
    output logic [7:0]        tx_byte,
    output logic              fcr_wr,
    output logic [7:0]        fcr_byte,
    output logic              fifo_mode,
    output logic [7:0]        lcr,
    output logic [7:0]        ier,
    output logic [7:0]        mcr,
    output logic [7:0]        irsel,
    output logic [15:0]       divisor
);

    localparam int unsigned SLOT_W = ADDR_W - 2;
    localparam int unsigned PAD_W  = DATA_W - 8;

    reg_id_t    rid;
    logic       do_wr, do_rd, flush, take;
    logic [7:0] wbyte, rx_byte, rd_byte_d;
    logic [7:0] lcr_q, ier_q, mcr_q, scr_q, irs_q, dll_q, dlm_q, fcr_q;
    logic       tx_wr_q, fcr_wr_q;
    logic [7:0] tx_byte_q;
    logic [DATA_W-1:0] rdata_q;
    logic       unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:8], bus_addr[1:0]};
    assign wbyte = bus_wdata[7:0];
    assign do_wr = bus_req && bus_wr;
    assign do_rd = bus_req && !bus_wr;

    uart_rb_decode #(.SLOT_W(SLOT_W)) u_dec (
        .slot     (bus_addr[ADDR_W-1:2]),
        .bank_sel (lcr_q[BANK_BIT]),
        .rid      (rid)
    );

    assign take  = do_rd && (rid == RID_DATA);
    assign flush = do_wr && (rid == RID_IDFC) && (wbyte[1] || (wbyte[0] != fcr_q[0]));

    uart_rb_rxpath #(.FIFO_DEPTH(FIFO_DEPTH)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_on  (fcr_q[0]),
        .flush    (flush),
        .rx_valid (rx_valid),
        .rx_char  (rx_char),
        .take     (take),
        .char_len (lcr_q[1:0]),
        .rd_byte  (rx_byte),
        .ready    (data_ready)
    );

    // Writable configuration bytes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= '0; ier_q <= '0; mcr_q <= '0; scr_q <= '0;
            irs_q <= '0; dll_q <= '0; dlm_q <= '0; fcr_q <= '0;
        end else if (do_wr) begin
            unique case (rid)
                RID_LCTL:  lcr_q <= wbyte;
                RID_IER:   ier_q <= wbyte;
                RID_MCTL:  mcr_q <= wbyte;
                RID_SCR:   scr_q <= wbyte;
                RID_IRS:   irs_q <= wbyte;
                RID_DIVLO: dll_q <= wbyte;
                RID_DIVHI: dlm_q <= wbyte;
                RID_IDFC:  fcr_q <= wbyte;
                default:   ;
            endcase
        end
    end

    // Load strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_wr_q   <= 1'b0;
            fcr_wr_q  <= 1'b0;
            tx_byte_q <= '0;
        end else begin
            tx_wr_q  <= do_wr && (rid == RID_DATA);
            fcr_wr_q <= do_wr && (rid == RID_IDFC);
            if (do_wr && (rid == RID_DATA)) tx_byte_q <= wbyte;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (rid)
            RID_DATA:  rd_byte_d = rx_byte;
            RID_IER:   rd_byte_d = ier_q;
            RID_DIVLO: rd_byte_d = dll_q;
            RID_DIVHI: rd_byte_d = dlm_q;
            RID_IDFC:  rd_byte_d = iir_in;
            RID_LCTL:  rd_byte_d = lcr_q;
            RID_MCTL:  rd_byte_d = mcr_q;
            RID_LSTAT: rd_byte_d = {lsr_in, data_ready};
            RID_MSTAT: rd_byte_d = msr_in;
            RID_SCR:   rd_byte_d = scr_q;
            RID_IRS:   rd_byte_d = irs_q;
            default:   rd_byte_d = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (do_rd) rdata_q <= {{PAD_W{1'b0}}, rd_byte_d};
    end

    assign bus_rdata = rdata_q;
    assign tx_wr     = tx_wr_q;
    assign tx_byte   = tx_byte_q;
    assign fcr_wr    = fcr_wr_q;
    assign fcr_byte  = fcr_q;
    assign fifo_mode = fcr_q[0];
    assign lcr       = lcr_q;
    assign ier       = ier_q;
    assign mcr       = mcr_q;
    assign irsel     = irs_q;
    assign divisor   = {dlm_q, dll_q};

endmodule

// File: rtl/uart_regbank_checker.sv
module uart_regbank_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              rx_valid,
    input logic              data_ready,
    input logic              tx_wr,
    input logic [7:0]        tx_byte,
    input logic              fcr_wr,
    input logic              fifo_mode,
    input logic [7:0]        lcr,
    input logic [7:0]        ier
);

    logic [ADDR_W-3:0] slot;
    assign slot = bus_addr[ADDR_W-1:2];

    // R1: data write in the normal bank strobes the transmitter
    a_r1_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && slot == 0 && !lcr[7])
        |=> (tx_wr && tx_byte == $past(bus_wdata[7:0])));

    // R2: divisor bank never strobes the transmitter nor touches ier
    a_r2_no_tx_in_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && slot <= 1 && lcr[7]) |=> (!tx_wr && $stable(ier)));

    // R3: FIFO control write produces its strobe
    a_r3_fcr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && slot == 2) |=> fcr_wr);

    // R5: line status bit 0 mirrors data-ready at the read
    a_r5_lsr_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && slot == 5) |=> (bus_rdata[0] == $past(data_ready)));

    // R6: non-FIFO data read with no arrival clears data-ready
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && slot == 0 && !lcr[7] && !fifo_mode && !rx_valid
         && !($past(bus_req) === 1'b0 && 1'b0))
        |=> !data_ready);

    // R6: an arriving character outside FIFO mode sets data-ready
    a_r6_arrival_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !fifo_mode && !(bus_req && bus_wr && slot == 2)) |=> data_ready);

    // R9: unmapped slots read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && slot > 8) |=> (bus_rdata == '0));

    // R4: upper read bits are always zero
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:8] == '0);

endmodule

bind uart_regbank uart_regbank_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rx_valid   (rx_valid),
    .data_ready (data_ready),
    .tx_wr      (tx_wr),
    .tx_byte    (tx_byte),
    .fcr_wr     (fcr_wr),
    .fifo_mode  (fifo_mode),
    .lcr        (lcr),
    .ier        (ier)
);

// File: tb/test_uart_regbank.sv
module test_uart_regbank;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_char = '0;
    logic [7:0]  iir_in = 8'h01, msr_in = 8'h00;
    logic [6:0]  lsr_in = 7'h30;
    logic        data_ready, tx_wr, fcr_wr, fifo_mode;
    logic [7:0]  tx_byte, fcr_byte, lcr, ier, mcr, irsel;
    logic [15:0] divisor;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_regbank i_uart_regbank (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_char(rx_char), .iir_in(iir_in),
        .msr_in(msr_in), .lsr_in(lsr_in), .data_ready(data_ready),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .fcr_wr(fcr_wr),
        .fcr_byte(fcr_byte), .fifo_mode(fifo_mode), .lcr(lcr), .ier(ier),
        .mcr(mcr), .irsel(irsel), .divisor(divisor)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [7:0] masked(input logic [7:0] c, input logic [1:0] len);
        return c & (8'hFF >> (3 - len));
    endfunction

    // Bench model of the receive side
    logic [7:0] mq[$];
    logic [7:0] m_hold = 8'h00;
    bit         m_fifo = 1'b0;
    logic [1:0] m_len  = 2'd3;

    function automatic logic [7:0] model_take();
        logic [7:0] v;
        if (m_fifo) v = (mq.size() != 0) ? mq.pop_front() : 8'h00;
        else begin v = m_hold; m_hold = 8'h00; end
        return masked(v, m_len);
    endfunction

    function automatic bit model_ready();
        return m_fifo ? (mq.size() != 0) : (m_hold_v != 0);
    endfunction

    bit m_hold_v = 0;

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 tx_wr", {31'b0, tx_wr}, 0);
        check("R10 data_ready", {31'b0, data_ready}, 0);
        check("R10 outputs", {lcr, ier, mcr, irsel}, 0);
        check("R10 divisor", {16'b0, divisor}, 0);
        rst_n = 1'b1;

        // R4 / R11
        wr(6'h0C, 32'hFFFF_FF03);
        check("R4 lcr", {24'b0, lcr}, 32'h03);
        wr(6'h1F, 32'h0000_00A5);
        rd(6'h1C, r); check("R11 scratch offset bits ignored", r, 32'hA5);
        wr(6'h10, 32'h1B); rd(6'h11, r); check("R4 mcr", r, 32'h1B);
        wr(6'h20, 32'h42); rd(6'h20, r); check("R4 irsel", r, 32'h42);
        check("R4 irsel port", {24'b0, irsel}, 32'h42);
        rd(6'h0C, r); check("R4 lcr read upper zero", r, 32'h03);

        // R1
        wr(6'h00, 32'h5A);
        check("R1 tx strobe", {23'b0, tx_wr, tx_byte}, 32'h15A);
        @(negedge clk);
        check("R1 tx strobe one cycle", {31'b0, tx_wr}, 0);
        wr(6'h04, 32'h0F); rd(6'h04, r); check("R1 ier", r, 32'h0F);

        // R2
        wr(6'h0C, 32'h83);
        wr(6'h00, 32'h34);
        check("R2 no tx in bank", {31'b0, tx_wr}, 0);
        wr(6'h04, 32'h12);
        check("R2 divisor", {16'b0, divisor}, 32'h1234);
        check("R2 ier kept", {24'b0, ier}, 32'h0F);
        rd(6'h00, r); check("R2 divlo read", r, 32'h34);
        rd(6'h04, r); check("R2 divhi read", r, 32'h12);
        iir_in = 8'hC1;
        rd(6'h08, r); check("R3 iir in bank", r, 32'hC1);
        wr(6'h0C, 32'h03);
        rd(6'h04, r); check("R2 ier back", r, 32'h0F);

        // R3
        rd(6'h08, r); check("R3 iir", r, 32'hC1);
        wr(6'h08, 32'h00);
        check("R3 fcr strobe", {23'b0, fcr_wr, fcr_byte}, 32'h100);

        // R5
        msr_in = 8'hB0;
        rd(6'h18, r); check("R5 msr", r, 32'hB0);
        rd(6'h14, r); check("R5 lsr empty", r, 32'h60);
        wr(6'h14, 32'hFF); wr(6'h18, 32'hFF);
        check("R5 writes ignored lcr", {24'b0, lcr}, 32'h03);
        check("R5 writes ignored dr", {31'b0, data_ready}, 0);

        // R6
        rx(8'h9C);
        check("R6 arrival sets dr", {31'b0, data_ready}, 1);
        rd(6'h14, r); check("R5 lsr ready", r, 32'h61);
        rd(6'h00, r); check("R6 read char", r, 32'h9C);
        check("R6 dr cleared", {31'b0, data_ready}, 0);
        rd(6'h00, r); check("R6 emptied", r, 32'h00);
        rx(8'h11); rx(8'h22);
        rd(6'h00, r); check("R6 overwrite", r, 32'h22);

        // R7
        for (int l = 0; l < 3; l++) begin
            wr(6'h0C, l);
            rx(8'hFF);
            rd(6'h00, r); check("R7 length mask", r, 32'(masked(8'hFF, 2'(l))));
        end
        wr(6'h0C, 32'h03);

        // R9
        for (int a = 6'h24; a <= 6'h3C; a += 4) begin
            rd(6'(a), r); check("R9 unmapped read", r, 0);
        end
        wr(6'h28, 32'h77);
        rd(6'h1C, r); check("R9 write no effect", r, 32'hA5);

        // R8
        wr(6'h08, 32'h01);
        check("R8 fifo_mode", {31'b0, fifo_mode}, 1);
        rx(8'hA1); rx(8'hA2); rx(8'hA3);
        rd(6'h00, r); check("R8 order 1", r, 32'hA1);
        rd(6'h00, r); check("R8 order 2", r, 32'hA2);
        check("R8 dr held", {31'b0, data_ready}, 1);
        rd(6'h00, r); check("R8 order 3", r, 32'hA3);
        check("R8 dr clears on last", {31'b0, data_ready}, 0);
        rd(6'h00, r); check("R8 empty read", r, 0);
        for (int i = 0; i <= DEPTH; i++) rx(8'(i + 8'h40));
        for (int i = 0; i < DEPTH; i++) begin
            rd(6'h00, r); check("R8 full drain", r, 32'(i + 8'h40));
        end
        check("R8 overflow dropped", {31'b0, data_ready}, 0);
        rx(8'h01); rx(8'h02);
        wr(6'h08, 32'h03);
        check("R8 flush", {31'b0, data_ready}, 0);
        rd(6'h00, r); check("R8 flush empties", r, 0);

        // R12
        rx(8'h55);
        wr(6'h08, 32'h00);
        check("R12 mode change clears dr", {31'b0, data_ready}, 0);
        rd(6'h00, r); check("R12 mode change empties", r, 0);

        // Random phase in both modes (R6, R7, R8)
        void'($urandom(32'd4242));
        for (int ph = 0; ph < 2; ph++) begin
            wr(6'h08, ph);
            m_fifo = ph[0]; mq.delete(); m_hold = 0; m_hold_v = 0;
            for (int it = 0; it < 300; it++) begin
                int op;
                op = $urandom_range(0, 3);
                if (op == 0) begin
                    logic [7:0] c;
                    c = 8'($urandom);
                    rx(c);
                    if (m_fifo) begin if (mq.size() < DEPTH) mq.push_back(c); end
                    else begin m_hold = c; m_hold_v = 1; end
                end else if (op == 1) begin
                    logic [7:0] e;
                    e = model_take(); m_hold_v = 0;
                    rd(6'h00, r);
                    check(m_fifo ? "R8 random read" : "R6 random read", r, 32'(e));
                end else if (op == 2) begin
                    rd(6'h14, r);
                    check("R5 random ready", {31'b0, r[0]}, {31'b0, model_ready()});
                end else begin
                    m_len = 2'($urandom);
                    wr(6'h0C, 32'(m_len));
                    check("R7 random length", {24'b0, lcr}, 32'(m_len));
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule